// File: doc/BRIEF.md
# Memory-Side Transaction Tracker

This block sits between the network and one memory bank. It takes read and write request messages that arrive from the network and parks each one in a tracking slot. When every slot is occupied, further requests wait in a first-in first-out queue instead of being lost. A slot that holds a new request is waiting for the bank. Once its command is accepted, the slot is marked as active. The slot is then marked complete one cycle before the bank's data comes back, so the reply stage is ready to act when the data arrives.

The bank is a fixed-latency request/response port. A command accepted in cycle t is answered in cycle t + `BANK_LAT`, and the answer carries the slot tag back. The reply side builds a message from the stored transaction id and source node and offers it to the network with a valid/ready handshake. The slot is freed on that handshake, and in the same cycle it is refilled from the head of the queue.

Top module: `mem_txn_tracker`

## Requirements
- R1: While reset is held and in the first cycle after release, `req_ready` is 1, `bank_cmd_valid` is 0 and `rep_valid` is 0.
- R2: A request accepted in cycle k while a slot is free and the queue is empty produces a bank command in cycle k+1. That command carries the request's address, its write flag (1 = write) and its write data.
- R3: A command accepted by the bank in cycle t yields a reply in cycle t + `BANK_LAT`, provided `rep_ready` is high. The reply carries the request's transaction id, source node and write flag. Its data is the bank data for a read and zero for a write.
- R4: At most one bank command is accepted per cycle. While `bank_cmd_ready` is low, waiting slots keep waiting. Among waiting slots, the earliest allocated issues first, whatever its slot index.
- R5: When all slots are busy, accepted requests go into a queue of `Q_DEPTH` entries and reach the bank only after a slot frees. Queued requests leave in arrival order. `req_ready` falls to 0 once the queue holds `Q_DEPTH` requests.
- R6: The queue head moves into a slot in the same cycle that slot is freed by a reply handshake. Its bank command appears in the next cycle.
- R7: A slot is marked complete one cycle before its bank data returns. The reply therefore leaves in the very cycle the data arrives, with no extra register stage.
- R8: While `rep_valid` is high and `rep_ready` is low, the offered reply and its data stay unchanged and the slot stays occupied. Bank data that returned during the wait is kept and delivered later. When several replies are ready, the earliest allocated goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Incoming request present |
| req_ready | output | 1 | Request can be taken (queue not full) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Memory address |
| req_wdata | input | DATA_W | Write data |
| req_txn | input | TXN_W | Transaction id of the requester |
| req_src | input | NODE_W | Requesting node |
| bank_cmd_valid | output | 1 | Bank command offered |
| bank_cmd_ready | input | 1 | Bank takes a command this cycle |
| bank_cmd_write | output | 1 | Command is a write |
| bank_cmd_addr | output | ADDR_W | Command address |
| bank_cmd_wdata | output | DATA_W | Command write data |
| bank_cmd_tag | output | TAG_W | Slot index of the command |
| bank_rsp_valid | input | 1 | Bank response present |
| bank_rsp_tag | input | TAG_W | Slot index of the response |
| bank_rsp_data | input | DATA_W | Response data |
| rep_valid | output | 1 | Reply offered to the network |
| rep_ready | input | 1 | Network takes the reply |
| rep_write | output | 1 | Reply answers a write |
| rep_txn | output | TXN_W | Transaction id echoed |
| rep_src | output | NODE_W | Requesting node echoed |
| rep_data | output | DATA_W | Read data (zero for writes) |

## Verification
Two functions can fall in the same cycle: a reply handshake frees a slot, and the queue head is written into that same slot. The bench provokes this by holding `rep_ready` low until the slots and the queue are both full, then releasing it. It judges the result by checking that the head's bank command appears one cycle after the reply. A second meeting point is bank data arriving in the cycle its reply is offered, which covers both the direct path and the case where the data is held. This is judged by the reply's cycle relative to the command and by the data value.

// File: rtl/mtt_pkg.sv
package mtt_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_BUSY = 2'd2,
    SLOT_DONE = 2'd3
  } slot_state_e;
endpackage

// File: rtl/mtt_req_fifo.sv
module mtt_req_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic             empty,
  output logic             full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign count   = cnt_q;
  assign dout    = mem_q[rp_q];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == PTR_W'(DEPTH-1)) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == PTR_W'(DEPTH-1)) ? '0 : rp_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= din;
  end
endmodule

// File: rtl/mtt_age_order.sv
module mtt_age_order #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         alloc,
  input  logic [N-1:0] alloc_oh,
  output logic [N-1:0] older_q [N]
);
  // older_q[a][b] set: slot a was allocated before slot b
  logic [N-1:0] older_d [N];

  always_comb begin
    for (int a = 0; a < N; a++) older_d[a] = older_q[a];
    for (int k = 0; k < N; k++) begin
      if (alloc && alloc_oh[k]) begin
        for (int j = 0; j < N; j++) begin
          older_d[k][j] = 1'b0;
          older_d[j][k] = (j != k);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < N; a++) older_q[a] <= '0;
    end else if (alloc) begin
      for (int a = 0; a < N; a++) older_q[a] <= older_d[a];
    end
  end
endmodule

// File: rtl/mtt_oldest_pick.sv
module mtt_oldest_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  input  logic [N-1:0] older [N],
  output logic [N-1:0] gnt
);
  logic [N-1:0] beaten;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      beaten[i] = 1'b0;
      for (int j = 0; j < N; j++) begin
        if ((j != i) && req[j] && older[j][i]) beaten[i] = 1'b1;
      end
      gnt[i] = req[i] && !beaten[i];
    end
  end
endmodule

// File: rtl/mem_txn_tracker.sv
module mem_txn_tracker #(
  parameter int NUM_ENT  = 4,
  parameter int Q_DEPTH  = 4,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int TXN_W    = 6,
  parameter int NODE_W   = 4,
  parameter int BANK_LAT = 4,
  localparam int TAG_W   = $clog2(NUM_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [TXN_W-1:0]  req_txn,
  input  logic [NODE_W-1:0] req_src,
  output logic              bank_cmd_valid,
  input  logic              bank_cmd_ready,
  output logic              bank_cmd_write,
  output logic [ADDR_W-1:0] bank_cmd_addr,
  output logic [DATA_W-1:0] bank_cmd_wdata,
  output logic [TAG_W-1:0]  bank_cmd_tag,
  input  logic              bank_rsp_valid,
  input  logic [TAG_W-1:0]  bank_rsp_tag,
  input  logic [DATA_W-1:0] bank_rsp_data,
  output logic              rep_valid,
  input  logic              rep_ready,
  output logic              rep_write,
  output logic [TXN_W-1:0]  rep_txn,
  output logic [NODE_W-1:0] rep_src,
  output logic [DATA_W-1:0] rep_data
);
  import mtt_pkg::*;

  localparam int REQ_W  = 1 + ADDR_W + DATA_W + TXN_W + NODE_W;
  localparam int CNT_W  = $clog2(BANK_LAT);
  localparam int QCNT_W = $clog2(Q_DEPTH+1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(BANK_LAT-3);

  initial begin
    if (BANK_LAT < 3) $error("BANK_LAT must be at least 3");
    if (NUM_ENT < 2)  $error("NUM_ENT must be at least 2");
  end

  function automatic logic [TAG_W-1:0] oh2idx(input logic [NUM_ENT-1:0] oh);
    logic [TAG_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < NUM_ENT; i++) if (oh[i]) idx = idx | TAG_W'(i);
    return idx;
  endfunction

  // per-slot control state
  slot_state_e      st_q  [NUM_ENT];
  slot_state_e      st_d  [NUM_ENT];
  logic [CNT_W-1:0] cnt_q [NUM_ENT];
  logic [CNT_W-1:0] cnt_d [NUM_ENT];
  logic [NUM_ENT-1:0] hd_q, hd_d;
  logic [NUM_ENT-1:0] ld_en, cap_en;

  // per-slot payload
  logic              wr_q    [NUM_ENT];
  logic [ADDR_W-1:0] addr_q  [NUM_ENT];
  logic [DATA_W-1:0] wdata_q [NUM_ENT];
  logic [TXN_W-1:0]  txn_q   [NUM_ENT];
  logic [NODE_W-1:0] src_q   [NUM_ENT];
  logic [DATA_W-1:0] data_q  [NUM_ENT];

  // status vectors
  logic [NUM_ENT-1:0] busy_vec, done_vec, wait_vec, rsp_hit, elig_vec;
  logic [NUM_ENT-1:0] iss_oh, rep_oh, free_vec, alloc_oh;
  logic [NUM_ENT-1:0] older [NUM_ENT];

  // queue and allocation
  logic [REQ_W-1:0]  inc_word, q_dout, alloc_word;
  logic              q_empty, q_full, q_push, q_pop;
  logic [QCNT_W-1:0] q_cnt;
  logic              req_acc, have_free, alloc, iss_fire, rep_fire;
  logic              a_write;
  logic [ADDR_W-1:0] a_addr;
  logic [DATA_W-1:0] a_wdata;
  logic [TXN_W-1:0]  a_txn;
  logic [NODE_W-1:0] a_src;
  logic [TAG_W-1:0]  iss_idx, rep_idx;

  assign inc_word  = {req_write, req_addr, req_wdata, req_txn, req_src};
  assign req_ready = !q_full;
  assign req_acc   = req_valid && req_ready;

  genvar g;
  generate
    for (g = 0; g < NUM_ENT; g++) begin : g_vec
      assign busy_vec[g] = (st_q[g] != SLOT_FREE);
      assign done_vec[g] = (st_q[g] == SLOT_DONE);
      assign wait_vec[g] = (st_q[g] == SLOT_WAIT);
      assign rsp_hit[g]  = bank_rsp_valid && (bank_rsp_tag == TAG_W'(g));
      assign elig_vec[g] = done_vec[g] && (hd_q[g] || rsp_hit[g]);
      assign free_vec[g] = !busy_vec[g] || (rep_fire && rep_oh[g]);
    end
  endgenerate

  // lowest-index free slot
  always_comb begin
    alloc_oh = '0;
    for (int i = NUM_ENT-1; i >= 0; i--) begin
      if (free_vec[i]) alloc_oh = NUM_ENT'(1) << i;
    end
  end

  assign have_free  = |free_vec;
  assign alloc      = have_free && (!q_empty || req_acc);
  assign q_pop      = have_free && !q_empty;
  assign q_push     = req_acc && !(have_free && q_empty);
  assign alloc_word = q_empty ? inc_word : q_dout;
  assign {a_write, a_addr, a_wdata, a_txn, a_src} = alloc_word;

  mtt_req_fifo #(.W(REQ_W), .DEPTH(Q_DEPTH)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (q_push),
    .din   (inc_word),
    .pop   (q_pop),
    .dout  (q_dout),
    .empty (q_empty),
    .full  (q_full),
    .count (q_cnt)
  );

  mtt_age_order #(.N(NUM_ENT)) u_age (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc    (alloc),
    .alloc_oh (alloc_oh),
    .older_q  (older)
  );

  mtt_oldest_pick #(.N(NUM_ENT)) u_iss_pick (
    .req   (wait_vec),
    .older (older),
    .gnt   (iss_oh)
  );

  mtt_oldest_pick #(.N(NUM_ENT)) u_rep_pick (
    .req   (elig_vec),
    .older (older),
    .gnt   (rep_oh)
  );

  // bank command side
  assign iss_idx        = oh2idx(iss_oh);
  assign bank_cmd_valid = |wait_vec;
  assign iss_fire       = bank_cmd_valid && bank_cmd_ready;
  assign bank_cmd_write = wr_q[iss_idx];
  assign bank_cmd_addr  = addr_q[iss_idx];
  assign bank_cmd_wdata = wdata_q[iss_idx];
  assign bank_cmd_tag   = iss_idx;

  // reply side
  assign rep_idx   = oh2idx(rep_oh);
  assign rep_valid = |elig_vec;
  assign rep_fire  = rep_valid && rep_ready;
  assign rep_write = wr_q[rep_idx];
  assign rep_txn   = txn_q[rep_idx];
  assign rep_src   = src_q[rep_idx];
  assign rep_data  = wr_q[rep_idx] ? '0 :
                     (hd_q[rep_idx] ? data_q[rep_idx] : bank_rsp_data);

  // slot next state
  always_comb begin
    for (int i = 0; i < NUM_ENT; i++) begin
      st_d[i]   = st_q[i];
      cnt_d[i]  = cnt_q[i];
      hd_d[i]   = hd_q[i];
      ld_en[i]  = 1'b0;
      cap_en[i] = 1'b0;
      case (st_q[i])
        SLOT_FREE: begin
          if (alloc && alloc_oh[i]) begin
            st_d[i]  = SLOT_WAIT;
            ld_en[i] = 1'b1;
          end
        end
        SLOT_WAIT: begin
          if (iss_fire && iss_oh[i]) begin
            st_d[i]  = SLOT_BUSY;
            cnt_d[i] = CNT_INIT;
          end
        end
        SLOT_BUSY: begin
          if (cnt_q[i] == '0) begin
            st_d[i] = SLOT_DONE;
            hd_d[i] = 1'b0;
          end else begin
            cnt_d[i] = cnt_q[i] - 1'b1;
          end
        end
        SLOT_DONE: begin
          if (rsp_hit[i]) begin
            hd_d[i]   = 1'b1;
            cap_en[i] = 1'b1;
          end
          if (rep_fire && rep_oh[i]) begin
            hd_d[i]   = 1'b0;
            cap_en[i] = 1'b0;
            if (alloc && alloc_oh[i]) begin
              st_d[i]  = SLOT_WAIT;
              ld_en[i] = 1'b1;
            end else begin
              st_d[i] = SLOT_FREE;
            end
          end
        end
        default: st_d[i] = SLOT_FREE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENT; i++) begin
        st_q[i]  <= SLOT_FREE;
        cnt_q[i] <= '0;
      end
      hd_q <= '0;
    end else begin
      for (int i = 0; i < NUM_ENT; i++) begin
        st_q[i]  <= st_d[i];
        cnt_q[i] <= cnt_d[i];
      end
      hd_q <= hd_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_ENT; i++) begin
      if (ld_en[i]) begin
        wr_q[i]    <= a_write;
        addr_q[i]  <= a_addr;
        wdata_q[i] <= a_wdata;
        txn_q[i]   <= a_txn;
        src_q[i]   <= a_src;
      end
      if (cap_en[i]) data_q[i] <= bank_rsp_data;
    end
  end
endmodule

// File: rtl/mtt_chk.sv
module mtt_chk #(
  parameter int NUM_ENT = 4,
  parameter int Q_DEPTH = 4,
  parameter int TAG_W   = 2,
  parameter int QCNT_W  = 3,
  parameter int TXN_W   = 6,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bank_cmd_valid,
  input logic [TAG_W-1:0]   bank_cmd_tag,
  input logic               bank_rsp_valid,
  input logic [TAG_W-1:0]   bank_rsp_tag,
  input logic               rep_valid,
  input logic               rep_ready,
  input logic [TXN_W-1:0]   rep_txn,
  input logic [DATA_W-1:0]  rep_data,
  input logic [NUM_ENT-1:0] busy_vec,
  input logic [NUM_ENT-1:0] done_vec,
  input logic [QCNT_W-1:0]  q_cnt
);
  // R2
  cmd_from_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_cmd_valid |-> (busy_vec[bank_cmd_tag] && !done_vec[bank_cmd_tag]));

  // R5
  queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= QCNT_W'(Q_DEPTH));

  // R6
  queue_only_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt != '0) |-> (&busy_vec));

  // R7
  rsp_hits_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_rsp_valid |-> done_vec[bank_rsp_tag]);

  genvar g;
  generate
    for (g = 0; g < NUM_ENT; g++) begin : g_done
      // R7
      done_before_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_vec[g]) |=> (bank_rsp_valid && (bank_rsp_tag == TAG_W'(g))));
    end
  endgenerate

  // R8
  reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && !rep_ready) |=> (rep_valid && $stable(rep_txn) && $stable(rep_data)));
endmodule

bind mem_txn_tracker mtt_chk #(
  .NUM_ENT (NUM_ENT),
  .Q_DEPTH (Q_DEPTH),
  .TAG_W   (TAG_W),
  .QCNT_W  (QCNT_W),
  .TXN_W   (TXN_W),
  .DATA_W  (DATA_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bank_cmd_valid (bank_cmd_valid),
  .bank_cmd_tag   (bank_cmd_tag),
  .bank_rsp_valid (bank_rsp_valid),
  .bank_rsp_tag   (bank_rsp_tag),
  .rep_valid      (rep_valid),
  .rep_ready      (rep_ready),
  .rep_txn        (rep_txn),
  .rep_data       (rep_data),
  .busy_vec       (busy_vec),
  .done_vec       (done_vec),
  .q_cnt          (q_cnt)
);

// File: tb/sim_mem_txn_tracker.sv
module sim_mem_txn_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NE   = 4;
  localparam int QD   = 4;
  localparam int AW   = 16;
  localparam int DW   = 32;
  localparam int TW   = 6;
  localparam int NW   = 4;
  localparam int LAT  = 4;
  localparam int TAGW = $clog2(NE);

  logic clk, rst_n;
  logic req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [TW-1:0] req_txn;
  logic [NW-1:0] req_src;
  logic bank_cmd_valid, bank_cmd_ready, bank_cmd_write;
  logic [AW-1:0] bank_cmd_addr;
  logic [DW-1:0] bank_cmd_wdata;
  logic [TAGW-1:0] bank_cmd_tag;
  logic bank_rsp_valid;
  logic [TAGW-1:0] bank_rsp_tag;
  logic [DW-1:0] bank_rsp_data;
  logic rep_valid, rep_ready, rep_write;
  logic [TW-1:0] rep_txn;
  logic [NW-1:0] rep_src;
  logic [DW-1:0] rep_data;

  int nchk = 0, nerr = 0, cyc = 0;

  mem_txn_tracker #(
    .NUM_ENT(NE), .Q_DEPTH(QD), .ADDR_W(AW), .DATA_W(DW),
    .TXN_W(TW), .NODE_W(NW), .BANK_LAT(LAT)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_txn(req_txn), .req_src(req_src),
    .bank_cmd_valid(bank_cmd_valid), .bank_cmd_ready(bank_cmd_ready),
    .bank_cmd_write(bank_cmd_write), .bank_cmd_addr(bank_cmd_addr),
    .bank_cmd_wdata(bank_cmd_wdata), .bank_cmd_tag(bank_cmd_tag),
    .bank_rsp_valid(bank_rsp_valid), .bank_rsp_tag(bank_rsp_tag),
    .bank_rsp_data(bank_rsp_data),
    .rep_valid(rep_valid), .rep_ready(rep_ready), .rep_write(rep_write),
    .rep_txn(rep_txn), .rep_src(rep_src), .rep_data(rep_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] bank_val(input logic [AW-1:0] a);
    return {a ^ 16'h5A3C, a};
  endfunction

  // fixed-latency bank model
  logic           bv [LAT];
  logic [TAGW-1:0] bt [LAT];
  logic [AW-1:0]  ba [LAT];
  logic           bw [LAT];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) bv[i] <= 1'b0;
    end else begin
      bv[0] <= bank_cmd_valid && bank_cmd_ready;
      bt[0] <= bank_cmd_tag;
      ba[0] <= bank_cmd_addr;
      bw[0] <= bank_cmd_write;
      for (int i = 1; i < LAT; i++) begin
        bv[i] <= bv[i-1]; bt[i] <= bt[i-1]; ba[i] <= ba[i-1]; bw[i] <= bw[i-1];
      end
    end
  end
  assign bank_rsp_valid = bv[LAT-1];
  assign bank_rsp_tag   = bt[LAT-1];
  assign bank_rsp_data  = bw[LAT-1] ? 32'hDEAD_0000 : bank_val(ba[LAT-1]);

  // handshake logs
  int ncmd = 0, nrep = 0;
  int cmd_cyc [64];
  logic [AW-1:0] cmd_addr [64];
  logic cmd_wr [64];
  logic [DW-1:0] cmd_wd [64];
  int rep_cyc [64];
  logic [TW-1:0] rep_txn_l [64];
  logic [NW-1:0] rep_src_l [64];
  logic [DW-1:0] rep_data_l [64];
  logic rep_wr_l [64];

  always begin
    @(negedge clk);
    #2;
    if (rst_n && bank_cmd_valid && bank_cmd_ready && ncmd < 64) begin
      cmd_cyc[ncmd] = cyc; cmd_addr[ncmd] = bank_cmd_addr;
      cmd_wr[ncmd] = bank_cmd_write; cmd_wd[ncmd] = bank_cmd_wdata;
      ncmd++;
    end
    if (rst_n && rep_valid && rep_ready && nrep < 64) begin
      rep_cyc[nrep] = cyc; rep_txn_l[nrep] = rep_txn; rep_src_l[nrep] = rep_src;
      rep_data_l[nrep] = rep_data; rep_wr_l[nrep] = rep_write;
      nrep++;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  int acc_cyc;
  // called at a negedge; returns at a negedge with req_valid low
  task automatic send(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [TW-1:0] t, input logic [NW-1:0] s);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    req_txn = t; req_src = s;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    acc_cyc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R1", "req_ready during reset", req_ready, 1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
    chk(bank_cmd_valid == 1'b0, "R1", "bank_cmd_valid", bank_cmd_valid, 0);
    chk(rep_valid == 1'b0, "R1", "rep_valid", rep_valid, 0);
  endtask

  task automatic t_single_read;
    int c0, r0, a0;
    c0 = ncmd; r0 = nrep;
    send(1'b0, 16'h0123, 32'h0, 6'd5, 4'd3);
    a0 = acc_cyc;
    idle(LAT + 4);
    chk(ncmd == c0 + 1, "R2", "read cmd count", ncmd - c0, 1);
    chk(cmd_cyc[c0] == a0 + 1, "R2", "read cmd cycle", cmd_cyc[c0], a0 + 1);
    chk(cmd_addr[c0] == 16'h0123 && cmd_wr[c0] == 1'b0, "R2", "read cmd addr",
        cmd_addr[c0], 16'h0123);
    chk(nrep == r0 + 1, "R3", "read reply count", nrep - r0, 1);
    chk(rep_cyc[r0] == cmd_cyc[c0] + LAT, "R7", "reply in data cycle",
        rep_cyc[r0], cmd_cyc[c0] + LAT);
    chk(rep_txn_l[r0] == 6'd5 && rep_src_l[r0] == 4'd3 && rep_wr_l[r0] == 1'b0,
        "R3", "read reply id/src", {rep_txn_l[r0], rep_src_l[r0]}, {6'd5, 4'd3});
    chk(rep_data_l[r0] == bank_val(16'h0123), "R3", "read reply data",
        rep_data_l[r0], bank_val(16'h0123));
  endtask

  task automatic t_write;
    int c0, r0;
    c0 = ncmd; r0 = nrep;
    send(1'b1, 16'h0456, 32'hCAFE_F00D, 6'd9, 4'd7);
    idle(LAT + 4);
    chk(ncmd == c0 + 1 && cmd_wr[c0] == 1'b1 && cmd_addr[c0] == 16'h0456,
        "R2", "write cmd", cmd_addr[c0], 16'h0456);
    chk(cmd_wd[c0] == 32'hCAFE_F00D, "R2", "write cmd data", cmd_wd[c0], 32'hCAFE_F00D);
    chk(nrep == r0 + 1 && rep_wr_l[r0] == 1'b1 && rep_txn_l[r0] == 6'd9,
        "R3", "write reply", rep_txn_l[r0], 6'd9);
    chk(rep_data_l[r0] == '0, "R3", "write reply data zero", rep_data_l[r0], 0);
    chk(rep_cyc[r0] == cmd_cyc[c0] + LAT, "R3", "write reply cycle",
        rep_cyc[r0], cmd_cyc[c0] + LAT);
  endtask

  task automatic t_order;
    int c0;
    c0 = ncmd;
    send(1'b0, 16'h0200, 32'h0, 6'd20, 4'd1);   // X -> slot 0
    @(negedge clk); bank_cmd_ready = 1'b0;
    send(1'b0, 16'h0201, 32'h0, 6'd21, 4'd1);   // Y -> slot 1
    send(1'b0, 16'h0202, 32'h0, 6'd22, 4'd1);   // Z -> slot 2
    idle(LAT + 4);                               // X replied, slot 0 free
    send(1'b0, 16'h0203, 32'h0, 6'd23, 4'd1);   // W -> slot 0, youngest
    idle(2);
    chk(ncmd == c0 + 1, "R4", "no cmd while bank not ready", ncmd - c0, 1);
    bank_cmd_ready = 1'b1;
    idle(LAT + 6);
    chk(ncmd == c0 + 4, "R4", "cmd count", ncmd - c0, 4);
    chk(cmd_addr[c0+1] == 16'h0201, "R4", "oldest first", cmd_addr[c0+1], 16'h0201);
    chk(cmd_addr[c0+2] == 16'h0202, "R4", "second", cmd_addr[c0+2], 16'h0202);
    chk(cmd_addr[c0+3] == 16'h0203, "R4", "youngest last", cmd_addr[c0+3], 16'h0203);
    chk(cmd_cyc[c0+2] == cmd_cyc[c0+1] + 1 && cmd_cyc[c0+3] == cmd_cyc[c0+2] + 1,
        "R4", "one cmd per cycle", cmd_cyc[c0+3] - cmd_cyc[c0+1], 2);
  endtask

  task automatic t_queue;
    int c0, r0, h;
    logic [TW-1:0] held;
    c0 = ncmd; r0 = nrep;
    rep_ready = 1'b0;
    for (int k = 0; k < NE + QD; k++)
      send(1'b0, AW'(16'h0300 + k), 32'h0, TW'(10 + k), NW'(k));
    #1;
    chk(req_ready == 1'b0, "R5", "req_ready low with queue full", req_ready, 0);
    idle(LAT + 3);
    chk(ncmd == c0 + NE, "R5", "queued requests not issued", ncmd - c0, NE);
    #1;
    held = rep_txn;
    chk(rep_valid == 1'b1, "R8", "reply offered", rep_valid, 1);
    idle(3);
    #1;
    chk(rep_valid == 1'b1 && rep_txn == held, "R8", "reply held stable", rep_txn, held);
    chk(held == 6'd10, "R8", "oldest reply offered", held, 10);
    @(negedge clk); rep_ready = 1'b1;
    idle(40);
    chk(nrep == r0 + NE + QD, "R5", "all replies", nrep - r0, NE + QD);
    for (int k = 0; k < NE + QD; k++) begin
      chk(rep_txn_l[r0+k] == TW'(10 + k), "R5", "reply order",
          rep_txn_l[r0+k], 10 + k);
      chk(rep_data_l[r0+k] == bank_val(AW'(16'h0300 + k)), "R8", "reply data",
          rep_data_l[r0+k], bank_val(AW'(16'h0300 + k)));
    end
    h = rep_cyc[r0];
    chk(cmd_addr[c0+NE] == 16'h0300 + NE, "R6", "queue head issued next",
        cmd_addr[c0+NE], 16'h0300 + NE);
    chk(cmd_cyc[c0+NE] == h + 1, "R6", "head cmd one cycle after free",
        cmd_cyc[c0+NE], h + 1);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; req_txn = '0; req_src = '0;
    bank_cmd_ready = 1'b1; rep_ready = 1'b1;
    idle(3);
    t_reset();
    t_single_read();
    t_write();
    t_order();
    t_queue();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule